// File: doc/BRIEF.md
# Four-Channel Event Timer with Free-Running Counter

This peripheral provides four identical countdown event timers and one free-running up-counter behind a small word-addressed register port. A single packed control word holds every channel's settings. For each event timer it holds a timebase select, a periodic flag and an enable bit. The free-running counter has a wider timebase select of its own and its own enable bit. An internal prescaler derives 1 µs, 10 µs, 100 µs and 1 ms ticks from the input clock, whose cycles-per-microsecond ratio is a parameter.

An event timer counts down from its loaded delay, one step per selected tick, and raises a one-cycle interrupt pulse when it expires. In periodic mode it reloads and keeps running. In one-shot mode it clears its own enable bit. Software drives a timer with a stop, load, start sequence: it clears the enable bit, writes the delay, then sets the enable bit together with the chosen mode. The free-running counter serves as a monotonic time base that software reads.

Top module: `sys_event_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: The control word is at byte offset 0x00. It holds these fields:
  - event timer t: timebase at bits [2t+1:2t], periodic flag at bit 12+t, enable at bit 16+t;
  - counter: timebase at bits [10:8], enable at bit 20.
  
  All other bits read as zero and ignore writes, so writing all ones reads back 0x001FF7FF.
- R3: Event timer t's value register is at byte offset 4*(t+1) (0x04, 0x08, 0x0C, 0x10). It reads back the timer's current count, zero-extended, with writes truncated to the counter width. A write while the timer is disabled loads both the count and the reload value. Unmapped offsets read zero.
- R4: A value write while the timer is enabled changes only the reload value. The interval in progress keeps its old length, and the new value applies from the next reload.
- R5: In one-shot mode a delay of N expires on the (N+1)th selected tick after the start. The timer then clears its own enable bit, leaves its count at zero and raises no further interrupt.
- R6: In periodic mode a delay of N gives exactly one expiry every N+1 selected ticks.
- R7: Event timebase codes 0, 1, 2 and 3 select ticks of 1, 10, 100 and 1000 µs, where 1 µs is CYCLES_PER_US input clock cycles.
- R8: The free-running counter at offset 0x14 increments by one per selected tick while bit 20 is set, and holds while bit 20 is clear. Its timebase codes are:
  - 0: every input clock;
  - 1 to 4: 1 µs, 10 µs, 100 µs and 1 ms;
  - 5 to 7: no tick.
- R9: The free-running counter wraps over its full width, and writes to offset 0x14 have no effect on it.
- R10: Clearing an enable bit freezes that timer's count, and it raises no interrupt while stopped. Setting the enable bit again restarts the countdown from the stored reload value.
- R11: Each expiry produces a one-cycle high pulse on the matching `irq_o` bit. The pulse comes from a register, in the cycle after the expiring tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 4 | Expiry pulse, one bit per event timer |

## Verification
The assertions relate the interrupt pulses, the counts and the control word. They assume two things about the bus. First, a write never hits the control word in the same cycle that a one-shot expiry clears an enable bit. Second, nothing except a value write or a running enable moves a count. The stimulus keeps to these assumptions. It issues one access at a time, never writes the control word within a cycle of an expected expiry, and starts a new channel only after the previous one has stopped. With 2 clock cycles per microsecond, all four event timebases and all eight counter codes can be swept with interval and latency bounds computed in cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_EVT = 4;

  // Writable bits of the control word
  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h001F_F7FF;

  localparam int IDX_CTRL     = 0;
  localparam int IDX_FREE     = 5;
  localparam int FREE_TB_LSB  = 8;
  localparam int FREE_EN_BIT  = 20;
  localparam int EVT_PER_BASE = 12;
  localparam int EVT_EN_BASE  = 16;

  typedef struct packed {
    logic every;
    logic us1;
    logic us10;
    logic us100;
    logic ms1;
  } tick_t;

  function automatic logic evt_tick_sel(input logic [1:0] code, input tick_t tk);
    logic sel;
    case (code)
      2'd0:    sel = tk.us1;
      2'd1:    sel = tk.us10;
      2'd2:    sel = tk.us100;
      default: sel = tk.ms1;
    endcase
    return sel;
  endfunction

  function automatic logic free_tick_sel(input logic [2:0] code, input tick_t tk);
    logic sel;
    case (code)
      3'd0:    sel = tk.every;
      3'd1:    sel = tk.us1;
      3'd2:    sel = tk.us10;
      3'd3:    sel = tk.us100;
      3'd4:    sel = tk.ms1;
      default: sel = 1'b0;
    endcase
    return sel;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CYCLES_PER_US = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output tmr_pkg::tick_t ticks_o
);
  localparam int DIV_W    = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
  localparam int NUM_DEC  = 3;
  localparam logic [3:0] DEC_LAST = 4'd9;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYCLES_PER_US - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             us_tick;
  logic [NUM_DEC:0] stage;

  assign us_tick  = (div_q == DIV_LAST);
  assign stage[0] = us_tick;

  always_comb begin
    div_d = us_tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  // Decade chain: each stage divides the previous tick by ten
  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    logic [3:0] cnt_q, cnt_d;
    logic       wrap;
    assign wrap = (cnt_q == DEC_LAST);
    always_comb begin
      cnt_d = wrap ? 4'd0 : cnt_q + 4'd1;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (stage[g]) cnt_q <= cnt_d;
    end
    assign stage[g+1] = stage[g] & wrap;
  end

  assign ticks_o.every = 1'b1;
  assign ticks_o.us1   = stage[0];
  assign ticks_o.us10  = stage[1];
  assign ticks_o.us100 = stage[2];
  assign ticks_o.ms1   = stage[3];
endmodule

// File: rtl/tmr_event_chan.sv
module tmr_event_chan #(
  parameter int EVT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             periodic_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [EVT_W-1:0] wdata_i,
  output logic [EVT_W-1:0] count_o,
  output logic             irq_o,
  output logic             done_o
);
  logic [EVT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic             en_q, irq_q;
  logic             start, step, at_zero, hit;

  assign start   = en_i & ~en_q;
  assign step    = en_i & en_q & tick_i;
  assign at_zero = (cnt_q == '0);
  assign hit     = step & at_zero;

  always_comb begin
    rld_d = rld_q;
    cnt_d = cnt_q;
    if (wr_i) begin
      rld_d = wdata_i;
      if (!en_i) cnt_d = wdata_i;
    end
    if (start) begin
      cnt_d = rld_d;
    end else if (step) begin
      if (!at_zero)        cnt_d = cnt_q - 1'b1;
      else if (periodic_i) cnt_d = rld_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      en_q  <= en_i;
      irq_q <= hit;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;
  assign done_o  = hit & ~periodic_i;
endmodule

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
  parameter int FREE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  output logic [FREE_W-1:0] count_o
);
  logic [FREE_W-1:0] cnt_q, cnt_d;
  logic              adv;

  assign adv = en_i & tick_i;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (adv) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/sys_event_timer.sv
module sys_event_timer #(
  parameter int CYCLES_PER_US = 24,
  parameter int EVT_W         = 32,
  parameter int FREE_W        = 32,
  parameter int ADDR_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [3:0]        irq_o
);
  import tmr_pkg::*;

  localparam int WORD_W = ADDR_W - 2;

  logic rst_meta_q, rst_n_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end
  assign rst_n = rst_n_q;

  logic [WORD_W-1:0] word_idx;
  logic              wr_stb, ctrl_wr;
  logic [NUM_EVT-1:0] val_wr, done, irq;
  logic [NUM_EVT-1:0][EVT_W-1:0] evt_cnt;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [FREE_W-1:0] free_cnt;
  logic              free_tick;
  tick_t             ticks;

  assign word_idx = bus_addr_i[ADDR_W-1:2];
  assign wr_stb   = bus_sel_i & bus_we_i;
  assign ctrl_wr  = wr_stb && (word_idx == WORD_W'(IDX_CTRL));

  tmr_prescaler #(.CYCLES_PER_US(CYCLES_PER_US)) presc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .ticks_o(ticks)
  );

  // Control word: software write wins over a one-shot self-clear
  always_comb begin
    ctrl_d = ctrl_q;
    for (int t = 0; t < NUM_EVT; t++) begin
      if (done[t]) ctrl_d[EVT_EN_BASE+t] = 1'b0;
    end
    if (ctrl_wr) ctrl_d = bus_wdata_i & CTRL_WMASK;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar t = 0; t < NUM_EVT; t++) begin : g_evt
    logic tick_sel;
    assign val_wr[t] = wr_stb && (word_idx == WORD_W'(t + 1));
    assign tick_sel  = evt_tick_sel(ctrl_q[2*t+1:2*t], ticks);
    tmr_event_chan #(.EVT_W(EVT_W)) chan_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .en_i      (ctrl_q[EVT_EN_BASE+t]),
      .periodic_i(ctrl_q[EVT_PER_BASE+t]),
      .tick_i    (tick_sel),
      .wr_i      (val_wr[t]),
      .wdata_i   (bus_wdata_i[EVT_W-1:0]),
      .count_o   (evt_cnt[t]),
      .irq_o     (irq[t]),
      .done_o    (done[t])
    );
  end

  assign free_tick = free_tick_sel(ctrl_q[FREE_TB_LSB+2:FREE_TB_LSB], ticks);

  tmr_free_counter #(.FREE_W(FREE_W)) free_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .en_i   (ctrl_q[FREE_EN_BIT]),
    .tick_i (free_tick),
    .count_o(free_cnt)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (word_idx == WORD_W'(IDX_CTRL)) bus_rdata_o = ctrl_q;
    if (word_idx == WORD_W'(IDX_FREE)) bus_rdata_o = 32'(free_cnt);
    for (int t = 0; t < NUM_EVT; t++) begin
      if (word_idx == WORD_W'(t + 1)) bus_rdata_o = 32'(evt_cnt[t]);
    end
  end

  assign irq_o = irq;
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int EVT_W  = 32,
  parameter int FREE_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [3:0]            irq_o,
  input logic [31:0]           ctrl_q,
  input logic                  ctrl_wr,
  input logic [3:0]            val_wr,
  input logic [FREE_W-1:0]     free_cnt,
  input logic                  free_tick,
  input logic [3:0][EVT_W-1:0] evt_cnt
);
  // R2: bits outside the writable mask never become set
  p_ctrl_unused_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~tmr_pkg::CTRL_WMASK) == 32'd0);

  // R8: an enabled counter advances by one on each selected tick
  p_free_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[20] && free_tick) |=> (free_cnt == FREE_W'($past(free_cnt) + 1'b1)));

  // R8: a disabled counter holds
  p_free_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[20] |=> $stable(free_cnt));

  for (genvar t = 0; t < 4; t++) begin : g_chk
    // R11: a pulse only follows a cycle in which the channel was enabled
    p_irq_from_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[t]) |-> $past(ctrl_q[16+t]));

    // R5: a one-shot expiry leaves the enable bit cleared
    p_oneshot_clears_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[t] && !$past(ctrl_q[12+t]) && !$past(ctrl_wr)) |-> !ctrl_q[16+t]);

    // R10: a stopped, unwritten channel keeps its count
    p_stopped_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_q[16+t] && !val_wr[t]) |=> $stable(evt_cnt[t]));
  end
endmodule

bind sys_event_timer tmr_bank_chk #(.EVT_W(EVT_W), .FREE_W(FREE_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .ctrl_q   (ctrl_q),
  .ctrl_wr  (ctrl_wr),
  .val_wr   (val_wr),
  .free_cnt (free_cnt),
  .free_tick(free_tick),
  .evt_cnt  (evt_cnt)
);

// File: tb/sys_event_timer_tb_top.sv
module sys_event_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int EVT_W      = 16;
  localparam int FREE_W     = 8;
  localparam int ADDR_W     = 8;
  localparam int WD_LIMIT   = 190000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sel, we;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata, rdata;
  logic [3:0]        irq;

  int n_vec = 0;
  int n_err = 0;
  int cyc = 0;
  int last_wr_cyc = 0;
  int pulse_err = 0;
  int irq_cnt [4];
  int irq_last [4];
  int irq_prev [4];
  logic [3:0] irq_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_event_timer #(
    .CYCLES_PER_US(CPU), .EVT_W(EVT_W), .FREE_W(FREE_W), .ADDR_W(ADDR_W)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    for (int t = 0; t < 4; t++) begin
      irq_cnt[t] = 0; irq_last[t] = 0; irq_prev[t] = 0;
    end
    irq_seen = '0;
  end

  always @(negedge clk) begin
    for (int t = 0; t < 4; t++) begin
      if (irq[t] === 1'b1) begin
        if (irq_seen[t]) pulse_err++;
        irq_cnt[t]++;
        irq_prev[t] = irq_last[t];
        irq_last[t] = cyc;
      end
      irq_seen[t] = (irq[t] === 1'b1);
    end
  end

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    last_wr_cyc = cyc;
    sel = 1'b1; we = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = ADDR_W'(a);
    #1 d = rdata;
    sel = 1'b0;
  endtask

  function automatic int tick_len(input int code);
    case (code)
      0: return CPU;
      1: return CPU * 10;
      2: return CPU * 100;
      default: return CPU * 1000;
    endcase
  endfunction

  task automatic wait_irq(input int ch, input int target, input int tmo);
    int w;
    w = 0;
    while (irq_cnt[ch] < target && w < tmo) begin
      @(negedge clk); #1;
      w++;
    end
    check(irq_cnt[ch] >= target, "R6 R5 expiry timeout", irq_cnt[ch], target);
  endtask

  task automatic oneshot(input int ch, input int code, input int n, input string req);
    int tl, base, s, lat;
    logic [31:0] d;
    tl = tick_len(code);
    wr(4*(ch+1), n);
    base = irq_cnt[ch];
    wr(0, (code << (2*ch)) | (1 << (16+ch)));
    s = last_wr_cyc;
    wait_irq(ch, base+1, (n+2)*tl + 50);
    lat = irq_last[ch] - s;
    check(lat >= n*tl+3 && lat <= (n+1)*tl+4, req, lat, (n+1)*tl+2);
    rd(0, d);
    check(d == 32'(code << (2*ch)), "R5 enable self-clear", d, code << (2*ch));
    rd(4*(ch+1), d);
    check(d == 0, "R5 count rests at zero", d, 0);
    repeat (2*tl + 10) @(negedge clk);
    check(irq_cnt[ch] == base+1, "R5 single expiry", irq_cnt[ch], base+1);
  endtask

  task automatic periodic(input int ch, input int code, input int n);
    int tl, base;
    tl = tick_len(code);
    wr(4*(ch+1), n);
    base = irq_cnt[ch];
    wr(0, (code << (2*ch)) | (1 << (12+ch)) | (1 << (16+ch)));
    wait_irq(ch, base+3, 4*(n+1)*tl + 100);
    check(irq_last[ch] - irq_prev[ch] == (n+1)*tl, "R6 R7 period",
          irq_last[ch] - irq_prev[ch], (n+1)*tl);
    wr(0, 0);
  endtask

  task automatic free_rate(input int code, input int k, input int exp);
    logic [31:0] a, b;
    wr(0, (1 << 20) | (code << 8));
    rd(20, a);
    repeat (k-1) @(negedge clk);
    rd(20, b);
    check(((b - a) & 32'hFF) == 32'(exp), "R8 counter rate", (b - a) & 32'hFF, exp);
  endtask

  initial begin
    logic [31:0] d, d2;
    int base;
    sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    check(irq == 4'd0, "R1 irq idle", irq, 0);
    rd(0, d); check(d == 0, "R1 control", d, 0);
    for (int t = 0; t < 4; t++) begin
      rd(4*(t+1), d); check(d == 0, "R1 value", d, 0);
    end
    rd(20, d); check(d == 0, "R1 counter", d, 0);

    // R2
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check(d == 32'h001F_F7FF, "R2 writable mask", d, 32'h001F_F7FF);
    wr(0, 0);
    rd(0, d); check(d == 0, "R2 cleared", d, 0);

    // R3
    for (int t = 0; t < 4; t++) begin
      wr(4*(t+1), 32'h1234_A5C0 + t);
      rd(4*(t+1), d);
      check(d == 32'hA5C0 + t, "R3 value readback", d, 32'hA5C0 + t);
    end
    rd(8'h18, d); check(d == 0, "R3 unmapped", d, 0);

    // R5 and R7: one-shot on every channel and timebase
    for (int t = 0; t < 4; t++) oneshot(t, t, t+1, "R5 R7 one-shot latency");

    // R6 and R7: periodic interval on every timebase
    for (int c = 0; c < 4; c++) periodic(3-c, c, 2);

    // R4: reload change while running
    wr(4, 4);
    base = irq_cnt[0];
    wr(0, (1 << 12) | (1 << 16));
    wait_irq(0, base+1, 100);
    wr(4, 9);
    wait_irq(0, base+2, 100);
    check(irq_last[0] - irq_prev[0] == 10, "R4 old interval kept", irq_last[0] - irq_prev[0], 10);
    wait_irq(0, base+3, 100);
    check(irq_last[0] - irq_prev[0] == 20, "R4 new reload applied", irq_last[0] - irq_prev[0], 20);

    // R10: stop freezes, restart from stored value
    wr(0, 0);
    rd(4, d);
    repeat (40) @(negedge clk);
    rd(4, d2);
    check(d == d2, "R10 frozen count", d2, d);
    check(irq_cnt[0] == base+3, "R10 silent while stopped", irq_cnt[0], base+3);
    wr(4, 3);
    rd(4, d); check(d == 3, "R10 load while stopped", d, 3);
    oneshot(0, 0, 3, "R10 restart latency");

    // R8: counter timebases and enable
    free_rate(0, 10, 10);
    free_rate(1, 20, 10);
    free_rate(2, 200, 10);
    free_rate(3, 2000, 10);
    free_rate(4, 20000, 10);
    free_rate(5, 100, 0);
    free_rate(7, 100, 0);
    wr(0, 0);
    rd(20, d); repeat (49) @(negedge clk); rd(20, d2);
    check(d == d2, "R8 disabled hold", d2, d);

    // R9: wrap and ignored write
    wr(0, 1 << 20);
    rd(20, d); repeat (299) @(negedge clk); rd(20, d2);
    check(d2 == ((d + 300) & 32'hFF), "R9 wrap", d2, (d + 300) & 32'hFF);
    rd(20, d);
    wr(20, 32'h5A);
    rd(20, d2);
    check(d2 == ((d + 3) & 32'hFF), "R9 write ignored", d2, (d + 3) & 32'hFF);
    wr(0, 0);

    // R11
    check(pulse_err == 0, "R11 single-cycle pulses", pulse_err, 0);
    finish_run();
  end
endmodule